// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 register reads and writes to an Ethernet PHY. A request gives a direction flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block derives the management clock from the system clock through a fixed divider. It drives a long run of ones, then the command and data bits, and then releases the data line for the turnaround and, on reads, for the returned data. When it finishes it gives a one-cycle completion pulse. Read data is presented on that pulse and held until the next read completes.

The data line is split into an output value, an active-high output enable and an input. A pad or tristate outside the block merges them. Only one request can be in flight. Any request made while the master is busy is dropped without effect.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever the block is idle, `mdc` is 0, `mdio_oe` is 0, `busy` is 0 and `done` is 0.
- R2: While busy, every low half and every high half of `mdc` lasts exactly `HALF_DIV` system clocks. Elaboration rejects any `HALF_DIV` that would push `mdc` above `MDC_MAX_HZ` at `SYS_CLK_HZ`.
- R3: Every frame opens with `PRE_CYCLES` (default 33) `mdc` cycles during which `mdio_oe`=1 and `mdio_o`=1.
- R4: A read then drives 16 bits, most significant first: 1,1,0,1,1,0, then PHY address bits 4..0, then register address bits 4..0.
- R5: A write then drives 32 bits, most significant first: 0,1,0,1, then PHY address bits 4..0, then register address bits 4..0, then 1,0, then data bits 15..0.
- R6: A read then holds `mdio_oe`=0 for 19 `mdc` cycles and samples `mdio_i` once in each. The result is samples 2 through 17 (counted from 0), with sample 2 as bit 15. The result appears on `rd_data`.
- R7: A write then holds `mdio_oe`=0 for exactly 2 more `mdc` cycles, so the frame has 67 cycles, against 68 for a read.
- R8: `mdio_o` and `mdio_oe` change only on the clock where `mdc` falls, or on the clock where a request is accepted. They are stable through each high half. `mdio_i` is taken on the last system clock of a low half.
- R9: A request (`req_valid`=1 while idle) raises `busy` on the next clock. `req_valid` while `busy`=1 is ignored: it does not alter the frame in progress and does not start another one.
- R10: `done` is a one-cycle pulse that falls with the last `mdc` high half, which is 2·`HALF_DIV`·(frame cycles) clocks after acceptance. `busy` drops on the same clock. `rd_data` updates only when a read completes.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable, active high |
| mdio_i | input | 1 | Data line sensed value |

## Verification
The PHY model drives the intended bit only during each low half of `mdc` and drives its inverse during the high half. A master that sampled after the rising edge would therefore return inverted data. The model also gives random values to the turnaround and idle samples, so a result window shifted by one bit would pick up wrong bits and mismatch. Every frame is checked bit by bit, together with its exact length and its exact latency to `done`, which catches a write that still clocks the 19-cycle read tail or a preamble that is one cycle short. Some frames get a foreign request injected mid-frame, and a design that restarted or re-latched on it would corrupt the frame or start a second one.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_CMD  = 2'd2,
      PH_TAIL = 2'd3
   } mdio_phase_e;

   localparam int SHIFT_W      = 32;
   localparam int RD_CMD_BITS  = 16;
   localparam int WR_CMD_BITS  = 32;
   localparam int RD_TAIL_BITS = 19;
   localparam int WR_TAIL_BITS = 2;
   localparam int DATA_W       = 16;
   localparam int ADDR_W       = 5;

   // Command word, left aligned so that bit 31 leaves first.
   function automatic logic [SHIFT_W-1:0] mdio_word(
      input logic              wr,
      input logic [ADDR_W-1:0] phy,
      input logic [ADDR_W-1:0] regad,
      input logic [DATA_W-1:0] wdat
   );
      if (wr)
         return {2'b01, 2'b01, phy, regad, 2'b10, wdat};
      else
         return {2'b11, 2'b01, 2'b10, phy, regad, 16'h0000};
   endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
   parameter int HALF_DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV + 1) : 1;

   logic mdc_q;
   logic at_end;

   generate
      if (HALF_DIV == 1) begin : g_fast
         assign at_end = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(HALF_DIV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (!run || at_end)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
         assign at_end = (cnt_q == CW'(HALF_DIV - 1));
      end
   endgenerate

   assign rise_tick = run & at_end & ~mdc_q;
   assign fall_tick = run & at_end &  mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mdc_q <= 1'b0;
      else if (!run)
         mdc_q <= 1'b0;
      else if (rise_tick || fall_tick)
         mdc_q <= ~mdc_q;
   end

   assign mdc = mdc_q;

   // Checker: measure each half period independently of the divider.
   logic [HW-1:0] hold_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         hold_q <= '0;
      else if (!run || (mdc_q != (rise_tick | mdc_q) ) || fall_tick)
         hold_q <= '0;
      else
         hold_q <= hold_q + 1'b1;
   end

   // R2
   half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run) && !$stable(mdc_q)) |-> ($past(hold_q) == HW'(HALF_DIV - 1)));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
   import mdio_pkg::*;
#(
   parameter int PRE_CYCLES = 33,
   parameter int BW         = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              start_wr,
   input  logic              fall_tick,
   output mdio_phase_e       phase,
   output logic              is_wr,
   output logic [BW-1:0]     bit_idx,
   output logic              last_fall,
   output logic              done
);
   mdio_phase_e   phase_q;
   logic          wr_q;
   logic [BW-1:0] bit_q;
   logic          done_q;
   int            last_bit;
   logic          phase_end;

   always_comb begin
      unique case (phase_q)
         PH_PRE:  last_bit = PRE_CYCLES - 1;
         PH_CMD:  last_bit = wr_q ? (WR_CMD_BITS - 1) : (RD_CMD_BITS - 1);
         PH_TAIL: last_bit = wr_q ? (WR_TAIL_BITS - 1) : (RD_TAIL_BITS - 1);
         default: last_bit = 0;
      endcase
   end

   assign phase_end = fall_tick && (int'(bit_q) == last_bit);
   assign last_fall = phase_end && (phase_q == PH_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wr_q    <= 1'b0;
         bit_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (phase_q == PH_IDLE) begin
            if (start) begin
               phase_q <= PH_PRE;
               wr_q    <= start_wr;
               bit_q   <= '0;
            end
         end else if (phase_end) begin
            bit_q <= '0;
            unique case (phase_q)
               PH_PRE:  phase_q <= PH_CMD;
               PH_CMD:  phase_q <= PH_TAIL;
               default: begin
                  phase_q <= PH_IDLE;
                  done_q  <= 1'b1;
               end
            endcase
         end else if (fall_tick) begin
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   assign phase   = phase_q;
   assign is_wr   = wr_q;
   assign bit_idx = bit_q;
   assign done    = done_q;

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter #(
   parameter int SW = 32,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [SW-1:0] load_word,
   input  logic          shift_en,
   input  logic          sample_en,
   input  logic          sin,
   output logic          sout,
   output logic [DW-1:0] captured
);
   logic [SW-1:0] out_q;
   logic [DW-1:0] in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         out_q <= '0;
      else if (load)
         out_q <= load_word;
      else if (shift_en)
         out_q <= {out_q[SW-2:0], 1'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         in_q <= '0;
      else if (sample_en)
         in_q <= {in_q[DW-2:0], sin};
   end

   assign sout     = out_q[SW-1];
   assign captured = in_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int SYS_CLK_HZ = 50_000_000,
   parameter int MDC_MAX_HZ = 2_500_000,
   parameter int HALF_DIV   = 10,
   parameter int PRE_CYCLES = 33
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [4:0]  req_phy,
   input  logic [4:0]  req_reg,
   input  logic [15:0] req_wdata,
   output logic        busy,
   output logic        done,
   output logic [15:0] rd_data,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   localparam int MAXLEN = (PRE_CYCLES > SHIFT_W) ? PRE_CYCLES : SHIFT_W;
   localparam int BW     = $clog2(MAXLEN);

   generate
      if (HALF_DIV < 1) begin : g_bad_div
         $error("HALF_DIV must be at least 1");
      end
      if (longint'(2) * longint'(HALF_DIV) * longint'(MDC_MAX_HZ) < longint'(SYS_CLK_HZ)) begin : g_too_fast
         $error("HALF_DIV gives an mdc rate above MDC_MAX_HZ");
      end
      if (PRE_CYCLES < 32) begin : g_short_pre
         $error("PRE_CYCLES must be at least 32");
      end
   endgenerate

   mdio_phase_e   phase;
   logic          is_wr;
   logic [BW-1:0] bit_idx;
   logic          last_fall;
   logic          rise_tick;
   logic          fall_tick;
   logic          accept;
   logic          sout;
   logic [15:0]   captured;
   logic          sample_en;
   logic [15:0]   rd_q;

   assign busy   = (phase != PH_IDLE);
   assign accept = req_valid & ~busy;

   mdio_clk_div #(.HALF_DIV(HALF_DIV)) i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_seq #(.PRE_CYCLES(PRE_CYCLES), .BW(BW)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (accept),
      .start_wr  (req_write),
      .fall_tick (fall_tick),
      .phase     (phase),
      .is_wr     (is_wr),
      .bit_idx   (bit_idx),
      .last_fall (last_fall),
      .done      (done)
   );

   // Keep only samples 2..17 of the 19-cycle read tail: skip the last one.
   assign sample_en = rise_tick && (phase == PH_TAIL) && !is_wr &&
                      (int'(bit_idx) >= 2) && (int'(bit_idx) < RD_TAIL_BITS - 1);

   mdio_shifter #(.SW(SHIFT_W), .DW(DATA_W)) i_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (mdio_word(req_write, req_phy, req_reg, req_wdata)),
      .shift_en  (fall_tick && (phase == PH_CMD)),
      .sample_en (sample_en),
      .sin       (mdio_i),
      .sout      (sout),
      .captured  (captured)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (last_fall && !is_wr)
         rd_q <= captured;
   end

   assign rd_data = rd_q;
   assign mdio_o  = (phase == PH_CMD) ? sout : 1'b1;
   assign mdio_oe = (phase == PH_PRE) || (phase == PH_CMD);

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc && !mdio_oe));

   // R8
   edge_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$stable({mdio_o, mdio_oe})) |-> ($fell(mdc) || $rose(busy)));

   // R9
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid));

   // R10
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy) && $fell(mdc)));

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;
   localparam int HALF = 10;
   localparam int PRE  = 33;
   localparam int NRD  = PRE + 16 + 19;
   localparam int NWR  = PRE + 32 + 2;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [4:0]  req_phy, req_reg;
   logic [15:0] req_wdata;
   logic        busy, done, mdc, mdio_o, mdio_oe, mdio_i;
   logic [15:0] rd_data;

   int n_chk = 0;
   int n_err = 0;

   always #10 clk = ~clk;

   mdio_master #(.HALF_DIV(HALF), .PRE_CYCLES(PRE)) i_mdio_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
      .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // Record the driven line at every rising mdc edge.
   logic rec_oe [0:127];
   logic rec_o  [0:127];
   int   nrise = 0;
   always @(posedge mdc) begin
      if (nrise < 128) begin
         rec_oe[nrise] = mdio_oe;
         rec_o[nrise]  = mdio_o;
      end
      nrise = nrise + 1;
   end

   // PHY model: wanted bit in low halves, its inverse in high halves.
   logic        cur_rd = 1'b0;
   logic [15:0] cur_data = '0;
   logic        ta0 = 1'b1, idle_b = 1'b1;
   logic        phy_b;
   always_comb begin
      int j;
      j = nrise - (PRE + 16);
      phy_b = 1'b1;
      if (cur_rd && j >= 0 && j <= 18) begin
         if (j == 0)       phy_b = ta0;
         else if (j == 1)  phy_b = 1'b0;
         else if (j == 18) phy_b = idle_b;
         else              phy_b = cur_data[17 - j];
      end
   end
   assign mdio_i = mdc ? ~phy_b : phy_b;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, expv);
      end
   endtask

   function automatic logic [31:0] exp_cmd(input bit wr, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] d);
      if (wr) return {2'b01, 2'b01, p, r, 2'b10, d};
      return {16'h0000, 4'b1101, 2'b10, p, r};
   endfunction

   logic [15:0] last_rd = '0;

   task automatic run_op(input bit wr, input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] d, input bit inject);
      int exp_n, lat, run_len, half_err, stab_err, pre_err, tail_err, cmd_len, rises_end;
      logic lastm;
      logic [31:0] capt, expw;
      exp_n = wr ? NWR : NRD;
      cmd_len = wr ? 32 : 16;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_phy = p; req_reg = r; req_wdata = d;
      cur_rd = !wr; cur_data = d;
      ta0 = 1'($urandom % 2); idle_b = 1'($urandom % 2);
      nrise = 0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R9", "busy after accept", {31'b0, busy}, 32'd1);
      lat = 0; run_len = 1; lastm = 1'b0; half_err = 0; stab_err = 0;
      while (done !== 1'b1 && lat < 4000) begin
         @(negedge clk);
         lat++;
         if (inject && lat == 300) begin
            req_valid = 1'b1; req_write = ~wr; req_phy = ~p; req_reg = ~r; req_wdata = ~d;
         end
         if (inject && lat == 301) req_valid = 1'b0;
         if (mdc === lastm) run_len++;
         else begin
            if (run_len != HALF) half_err++;
            run_len = 1; lastm = mdc;
         end
         if (mdc === 1'b1 && nrise > 0 && nrise <= 128)
            if (mdio_o !== rec_o[nrise-1] || mdio_oe !== rec_oe[nrise-1]) stab_err++;
      end
      chk(lat == 2*HALF*exp_n, "R10", "latency to done", lat, 2*HALF*exp_n);
      chk(busy === 1'b0, "R10", "busy low with done", {31'b0, busy}, 32'd0);
      chk(nrise == exp_n, wr ? "R7" : "R6", "mdc cycles in frame", nrise, exp_n);
      chk(half_err == 0, "R2", "half period errors", half_err, 0);
      chk(stab_err == 0, "R8", "changes during high half", stab_err, 0);
      pre_err = 0;
      for (int k = 0; k < PRE; k++)
         if (rec_oe[k] !== 1'b1 || rec_o[k] !== 1'b1) pre_err++;
      chk(pre_err == 0, "R3", "preamble bits wrong", pre_err, 0);
      capt = '0;
      for (int k = 0; k < cmd_len; k++)
         if (PRE + k < 128) capt = {capt[30:0], (rec_oe[PRE+k] === 1'b1) ? rec_o[PRE+k] : 1'bx};
      expw = exp_cmd(wr, p, r, d);
      chk(capt === expw, wr ? "R5" : "R4", "command bits", capt, expw);
      tail_err = 0;
      for (int k = PRE + cmd_len; k < exp_n && k < 128; k++)
         if (rec_oe[k] !== 1'b0) tail_err++;
      chk(tail_err == 0, wr ? "R7" : "R6", "tail drive enable", tail_err, 0);
      if (!wr) begin
         chk(rd_data === d, "R6", "read data", {16'h0, rd_data}, {16'h0, d});
         last_rd = d;
      end else begin
         chk(rd_data === last_rd, "R10", "rd_data held over write", {16'h0, rd_data}, {16'h0, last_rd});
      end
      rises_end = nrise;
      @(negedge clk);
      chk(done === 1'b0, "R10", "done width", {31'b0, done}, 32'd0);
      if (inject) begin
         repeat (4) @(negedge clk);
         chk(busy === 1'b0 && nrise == rises_end, "R9", "no frame from ignored request",
             {31'b0, busy}, 32'd0);
      end
      cur_rd = 1'b0;
   endtask

   initial begin
      int seed_ret;
      seed_ret = $urandom(32'h5EED_0042);
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_phy = '0; req_reg = '0; req_wdata = '0;
      repeat (3) @(negedge clk);
      chk(mdc === 1'b0 && mdio_oe === 1'b0 && busy === 1'b0 && done === 1'b0, "R1",
          "reset outputs", {28'b0, mdc, mdio_oe, busy, done}, 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(mdc === 1'b0 && mdio_oe === 1'b0 && busy === 1'b0, "R1",
          "idle outputs", {29'b0, mdc, mdio_oe, busy}, 32'd0);
      // Directed corners
      run_op(1'b0, 5'd0,  5'd0,  16'h0000, 1'b0);
      run_op(1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b0);
      run_op(1'b1, 5'd31, 5'd31, 16'hFFFF, 1'b0);
      run_op(1'b1, 5'd0,  5'd0,  16'h0000, 1'b1);
      run_op(1'b0, 5'd10, 5'd21, 16'hA55A, 1'b1);
      run_op(1'b1, 5'd21, 5'd10, 16'h8001, 1'b0);
      // Random mix
      for (int i = 0; i < 20; i++)
         run_op(1'($urandom % 2), 5'($urandom), 5'($urandom), 16'($urandom), (i % 4) == 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule